// File: doc/BRIEF.md
# Multichannel Waveform Playback Sequencer

This block drives a bank of 32 analog output words (16 bits each) and one 64-bit digital output word, and changes all of them together on the same clock edge, marked by a one-cycle update strobe. It has three kinds of operation. In registered modes the host sets static DC values channel by channel. In streamed waveform modes the host fills a FIFO with channel-interleaved frames, and each sample tick moves one frame to the outputs. In low-latency modes one wide write carries the whole output vector. Registered and waveform modes each come in an immediate variant and a variant that waits for a trigger pulse. The low-latency modes come in an immediate variant and a variant that waits for the sample tick.

The host starts and stops streaming with a commit word. Bit 0 applies the DC values. Bit 1 arms or starts playback. Bit 5 selects one-shot playback, which presents a programmed number of frames and then holds the last one. A low-tide interrupt asks the host to refill the FIFO while streaming. A sample tick that finds no complete frame leaves the outputs unchanged and sets a sticky overrun flag, which stays set until the host clears it.

The sample tick and the trigger arrive as single-cycle enables from outside the block. Clock division, edge selection and the DAC serial links are not part of this block.

Top module: `wpb_seq`

## Requirements
- R1: While reset is held and right after it is released, every analog and digital output is zero, and update strobe, playing, done, overrun and low-tide interrupt are all low.
- R2: In mode 0 (registered immediate), a DC write updates exactly one output in the following cycle and pulses the update strobe for one cycle. Select 0..31 picks an analog channel and takes data bits [15:0]. Select 32 loads digital bits [31:0] and select 33 loads digital bits [63:32]. Any other select changes nothing and gives no strobe. A commit with bit 0 set copies every stored DC value to the outputs at once.
- R3: In mode 1 (registered triggered), DC writes are stored but do not reach the outputs. A commit with bit 0 set arms one update, and the next trigger pulse then copies all stored DC values to the outputs. A trigger that arrives while nothing is armed changes nothing.
- R4: A stream frame is 18 FIFO words of 32 bits. Word k (k = 0..15) carries channel 2k in bits [15:0] and channel 2k+1 in bits [31:16]. Word 16 is digital bits [31:0] and word 17 is digital bits [63:32].
- R5: In mode 2 (waveform immediate), a commit with bit 1 set starts playback at once. Each sample tick that finds a complete frame presents all 32 channels and the digital word in the following cycle, with one update strobe.
- R6: In mode 3 (waveform triggered), a commit with bit 1 set only arms playback. Sample ticks before the trigger change no output. The trigger pulse starts playback.
- R7: With commit bit 5 set, playback stops after the number of frames given on the frame-length input when the commit was taken. At that point done goes high, playing goes low, and the last frame stays on the outputs through later ticks. Without bit 5, playback continues past that count.
- R8: The low-tide interrupt is high exactly while playback is armed or running and the FIFO fill level is below the low-tide threshold input.
- R9: A sample tick during playback with no complete frame leaves every output unchanged, gives no strobe and sets the overrun flag. The flag stays set until an overrun-clear pulse.
- R10: In mode 4 (low-latency immediate), a low-latency write drives every output from the wide write data in the following cycle.
- R11: In mode 5 (low-latency clocked), a low-latency write is held back and reaches the outputs on the next sample tick.
- R12: In waveform modes, DC and low-latency writes leave the outputs unchanged. In registered modes, sample ticks leave the outputs unchanged.
- R13: A commit with bit 1 clear halts playback and clears playing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Operating mode, encoded 0..5 as in R2, R3, R5, R6, R10 and R11 |
| commit_wr_i | input | 1 | Commit word strobe |
| commit_i | input | 8 | Commit word: bit 0 applies DC, bit 1 plays, bit 5 selects one-shot |
| trig_i | input | 1 | Single-cycle trigger pulse |
| sample_en_i | input | 1 | Single-cycle sample tick |
| fifo_wr_i | input | 1 | FIFO write strobe |
| fifo_wdata_i | input | 32 | FIFO write word |
| fifo_full_o | output | 1 | FIFO full |
| fifo_level_o | output | 7 | FIFO fill level in words |
| lowtide_i | input | 7 | Low-tide threshold in words |
| frame_len_i | input | 16 | One-shot length in frames |
| dc_wr_i | input | 1 | DC write strobe |
| dc_sel_i | input | 6 | DC target select |
| dc_data_i | input | 32 | DC write data |
| ll_wr_i | input | 1 | Low-latency write strobe |
| ll_ao_i | input | 512 | Low-latency analog vector, channel c in bits [16c+15:16c] |
| ll_do_i | input | 64 | Low-latency digital vector |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| ao_data_o | output | 512 | Analog outputs, channel c in bits [16c+15:16c] |
| do_data_o | output | 64 | Digital outputs |
| upd_o | output | 1 | Common update strobe |
| playing_o | output | 1 | Playback running |
| done_o | output | 1 | One-shot playback finished |
| overrun_o | output | 1 | Sticky starvation flag |
| lowtide_irq_o | output | 1 | Low-tide refill interrupt |

## Verification
The bench looks for the places where the output path can leak or fire at the wrong time. A design that drops the arming step would let a stray trigger or an early sample tick move the outputs in the triggered modes. A design that loads a partial frame on a starved tick would show torn channel values and a false strobe instead of holding the outputs and raising overrun. A one-shot counter that is off by one would give one frame too many or too few before done, and a design that ignores bit 5 would stop continuous playback early. The bench also places recognisable values in every channel slot, so a swapped half-word or a misplaced digital word in the frame layout shows up on the ports. Writes of the wrong kind for the current mode must not reach the outputs.

// File: rtl/wpb_pkg.sv
// Shared definitions for the waveform playback sequencer.
// Assumes: mode and commit-word encodings are fixed by the host software.
package wpb_pkg;

    typedef enum logic [2:0] {
        MODE_REG_IMM   = 3'd0,
        MODE_REG_TRIG  = 3'd1,
        MODE_WAVE_IMM  = 3'd2,
        MODE_WAVE_TRIG = 3'd3,
        MODE_LL_IMM    = 3'd4,
        MODE_LL_CLK    = 3'd5
    } play_mode_e;

    localparam int COMMIT_DC_BIT   = 0;
    localparam int COMMIT_PLAY_BIT = 1;
    localparam int COMMIT_ONCE_BIT = 5;

    function automatic logic is_wave(input play_mode_e m);
        return (m == MODE_WAVE_IMM) || (m == MODE_WAVE_TRIG);
    endfunction

endpackage

// File: rtl/wpb_fifo.sv
// Synchronous word FIFO with a fill-level output.
// Assumes: DEPTH is a power of two; a push to a full FIFO or a pop from an
// empty one is dropped. Read data is the head word, valid while not empty.
module wpb_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic [W-1:0]               wdata_i,
    input  logic                       pop_i,
    output logic [W-1:0]               rdata_o,
    output logic                       empty_o,
    output logic                       full_o,
    output logic [$clog2(DEPTH):0]     level_o
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [AW:0]   cnt_q;
    logic          do_push, do_pop;

    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == (AW+1)'(DEPTH));
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign rdata_o = mem[rptr_q];
    assign level_o = cnt_q;

    // Storage array write, no reset needed on data
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr_q] <= wdata_i;
    end

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wptr_q <= wptr_q + 1'b1;
            if (do_pop)  rptr_q <= rptr_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/wpb_frame_asm.sv
// De-multiplexes interleaved FIFO words into one complete output frame.
// Assumes: word k < AO_WORDS holds consecutive analog channels packed low
// first; the digital words follow. Holds one ready frame until taken.
module wpb_frame_asm #(
    parameter int W    = 32,
    parameter int N_AO = 32,
    parameter int AO_W = 16,
    parameter int DO_W = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en_i,
    input  logic                   fifo_empty_i,
    input  logic [W-1:0]           fifo_data_i,
    output logic                   pop_o,
    input  logic                   take_i,
    output logic                   ready_o,
    output logic [N_AO*AO_W-1:0]   ao_o,
    output logic [DO_W-1:0]        do_o
);
    localparam int AO_WORDS    = (N_AO * AO_W) / W;
    localparam int DO_WORDS    = DO_W / W;
    localparam int FRAME_WORDS = AO_WORDS + DO_WORDS;
    localparam int CW          = $clog2(FRAME_WORDS + 1);

    logic [W-1:0]  words_q [FRAME_WORDS];
    logic [CW-1:0] cnt_q;
    logic          ready_q;

    assign ready_o = ready_q;
    assign pop_o   = en_i && !ready_q && !fifo_empty_i;

    // Map stored words onto the flat frame buses
    for (genvar k = 0; k < AO_WORDS; k++) begin : g_ao_map
        assign ao_o[k*W +: W] = words_q[k];
    end
    for (genvar j = 0; j < DO_WORDS; j++) begin : g_do_map
        assign do_o[j*W +: W] = words_q[AO_WORDS + j];
    end

    // Collect words in order and flag a full frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ready_q <= 1'b0;
            for (int i = 0; i < FRAME_WORDS; i++) words_q[i] <= '0;
        end else if (take_i) begin
            ready_q <= 1'b0;
        end else if (pop_o) begin
            words_q[cnt_q] <= fifo_data_i;
            if (cnt_q == CW'(FRAME_WORDS - 1)) begin
                cnt_q   <= '0;
                ready_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wpb_ctrl.sv
// Mode, commit-word and playback sequencing for the playback block.
// Assumes: trig_i and sample_en_i are single-cycle enables already aligned
// to clk; mode_i is steady around a commit.
module wpb_ctrl #(
    parameter int LVL_W = 7,
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic              commit_wr_i,
    input  logic [7:0]        commit_i,
    input  logic              trig_i,
    input  logic              sample_en_i,
    input  logic              frame_ready_i,
    input  logic [LEN_W-1:0]  frame_len_i,
    input  logic [LVL_W-1:0]  fifo_level_i,
    input  logic [LVL_W-1:0]  lowtide_i,
    input  logic              ovr_clr_i,
    output logic              asm_en_o,
    output logic              present_o,
    output logic              dc_fire_o,
    output logic              playing_o,
    output logic              done_o,
    output logic              overrun_o,
    output logic              lowtide_irq_o
);
    import wpb_pkg::*;

    play_mode_e       mode;
    logic             wave_mode, starve, trig_fire;
    logic             armed_q, playing_q, dc_armed_q, once_q, done_q, overrun_q;
    logic [LEN_W-1:0] len_q, fcnt_q;
    logic [LEN_W:0]   fcnt_nx;
    logic             unused_commit_bits;

    assign mode      = play_mode_e'(mode_i);
    assign wave_mode = is_wave(mode);
    assign present_o = playing_q && wave_mode && sample_en_i && frame_ready_i;
    assign starve    = playing_q && wave_mode && sample_en_i && !frame_ready_i;
    assign trig_fire = (mode == MODE_REG_TRIG) && dc_armed_q && trig_i;
    assign dc_fire_o = trig_fire ||
                       ((mode == MODE_REG_IMM) && commit_wr_i && commit_i[COMMIT_DC_BIT]);
    assign fcnt_nx   = {1'b0, fcnt_q} + 1'b1;

    assign asm_en_o      = armed_q || playing_q;
    assign lowtide_irq_o = asm_en_o && (fifo_level_i < lowtide_i);
    assign playing_o     = playing_q;
    assign done_o        = done_q;
    assign overrun_o     = overrun_q;
    assign unused_commit_bits = ^{commit_i[7:6], commit_i[4:2]};

    // Sticky starvation flag; a new starvation wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)              overrun_q <= 1'b0;
        else if (starve)         overrun_q <= 1'b1;
        else if (ovr_clr_i)      overrun_q <= 1'b0;
    end

    // Arming of a triggered DC update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dc_armed_q <= 1'b0;
        end else if (commit_wr_i && commit_i[COMMIT_DC_BIT] && mode == MODE_REG_TRIG) begin
            dc_armed_q <= 1'b1;
        end else if (trig_fire) begin
            dc_armed_q <= 1'b0;
        end
    end

    // Playback start, trigger gate, frame counting and stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            playing_q <= 1'b0;
            once_q    <= 1'b0;
            done_q    <= 1'b0;
            len_q     <= '0;
            fcnt_q    <= '0;
        end else if (commit_wr_i) begin
            if (commit_i[COMMIT_PLAY_BIT] && wave_mode) begin
                once_q <= commit_i[COMMIT_ONCE_BIT];
                len_q  <= frame_len_i;
                fcnt_q <= '0;
                done_q <= 1'b0;
                if (mode == MODE_WAVE_IMM) begin
                    playing_q <= 1'b1;
                    armed_q   <= 1'b0;
                end else begin
                    playing_q <= 1'b0;
                    armed_q   <= 1'b1;
                end
            end else if (!commit_i[COMMIT_PLAY_BIT]) begin
                playing_q <= 1'b0;
                armed_q   <= 1'b0;
            end
        end else begin
            if (armed_q && trig_i && mode == MODE_WAVE_TRIG) begin
                playing_q <= 1'b1;
                armed_q   <= 1'b0;
            end
            if (present_o) begin
                fcnt_q <= fcnt_nx[LEN_W-1:0];
                if (once_q && fcnt_nx >= {1'b0, len_q}) begin
                    playing_q <= 1'b0;
                    done_q    <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wpb_seq.sv
// Top of the multichannel waveform playback sequencer: FIFO, frame
// de-multiplexer, control, DC and low-latency shadows, output registers.
// Assumes: all outputs change together and only with a one-cycle upd_o.
module wpb_seq #(
    parameter int N_AO       = 32,
    parameter int AO_W       = 16,
    parameter int DO_W       = 64,
    parameter int WORD_W     = 32,
    parameter int FIFO_DEPTH = 64,
    parameter int LEN_W      = 16,
    parameter int LVL_W      = $clog2(FIFO_DEPTH) + 1,
    parameter int SEL_W      = $clog2(N_AO + DO_W / WORD_W)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             mode_i,
    input  logic                   commit_wr_i,
    input  logic [7:0]             commit_i,
    input  logic                   trig_i,
    input  logic                   sample_en_i,
    input  logic                   fifo_wr_i,
    input  logic [WORD_W-1:0]      fifo_wdata_i,
    output logic                   fifo_full_o,
    output logic [LVL_W-1:0]       fifo_level_o,
    input  logic [LVL_W-1:0]       lowtide_i,
    input  logic [LEN_W-1:0]       frame_len_i,
    input  logic                   dc_wr_i,
    input  logic [SEL_W-1:0]       dc_sel_i,
    input  logic [WORD_W-1:0]      dc_data_i,
    input  logic                   ll_wr_i,
    input  logic [N_AO*AO_W-1:0]   ll_ao_i,
    input  logic [DO_W-1:0]        ll_do_i,
    input  logic                   ovr_clr_i,
    output logic [N_AO*AO_W-1:0]   ao_data_o,
    output logic [DO_W-1:0]        do_data_o,
    output logic                   upd_o,
    output logic                   playing_o,
    output logic                   done_o,
    output logic                   overrun_o,
    output logic                   lowtide_irq_o
);
    import wpb_pkg::*;

    localparam int AO_BUS   = N_AO * AO_W;
    localparam int DO_WORDS = DO_W / WORD_W;
    localparam int N_SEL    = N_AO + DO_WORDS;

    play_mode_e        mode;
    logic [WORD_W-1:0] fifo_rdata;
    logic              fifo_empty, fifo_pop;
    logic              asm_en, frame_ready, present, dc_fire;
    logic [AO_BUS-1:0] frame_ao;
    logic [DO_W-1:0]   frame_do;

    logic [AO_BUS-1:0] ao_q, dc_ao_q, dc_ao_nx, ao_wr, ll_ao_q;
    logic [DO_W-1:0]   do_q, dc_do_q, dc_do_nx, do_wr, ll_do_q;
    logic              upd_q, ll_pend_q, dc_valid;

    assign mode     = play_mode_e'(mode_i);
    assign dc_valid = dc_wr_i && ({1'b0, dc_sel_i} < (SEL_W+1)'(N_SEL));

    wpb_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (fifo_wr_i),
        .wdata_i (fifo_wdata_i),
        .pop_i   (fifo_pop),
        .rdata_o (fifo_rdata),
        .empty_o (fifo_empty),
        .full_o  (fifo_full_o),
        .level_o (fifo_level_o)
    );

    wpb_frame_asm #(.W(WORD_W), .N_AO(N_AO), .AO_W(AO_W), .DO_W(DO_W)) u_asm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (asm_en),
        .fifo_empty_i (fifo_empty),
        .fifo_data_i  (fifo_rdata),
        .pop_o        (fifo_pop),
        .take_i       (present),
        .ready_o      (frame_ready),
        .ao_o         (frame_ao),
        .do_o         (frame_do)
    );

    wpb_ctrl #(.LVL_W(LVL_W), .LEN_W(LEN_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode_i),
        .commit_wr_i   (commit_wr_i),
        .commit_i      (commit_i),
        .trig_i        (trig_i),
        .sample_en_i   (sample_en_i),
        .frame_ready_i (frame_ready),
        .frame_len_i   (frame_len_i),
        .fifo_level_i  (fifo_level_o),
        .lowtide_i     (lowtide_i),
        .ovr_clr_i     (ovr_clr_i),
        .asm_en_o      (asm_en),
        .present_o     (present),
        .dc_fire_o     (dc_fire),
        .playing_o     (playing_o),
        .done_o        (done_o),
        .overrun_o     (overrun_o),
        .lowtide_irq_o (lowtide_irq_o)
    );

    // Per-channel merge of a DC write into the shadow and into the outputs
    for (genvar c = 0; c < N_AO; c++) begin : g_dc_ao
        logic hit;
        assign hit = dc_wr_i && (dc_sel_i == SEL_W'(c));
        assign dc_ao_nx[c*AO_W +: AO_W] = hit ? dc_data_i[AO_W-1:0] : dc_ao_q[c*AO_W +: AO_W];
        assign ao_wr[c*AO_W +: AO_W]    = hit ? dc_data_i[AO_W-1:0] : ao_q[c*AO_W +: AO_W];
    end
    for (genvar j = 0; j < DO_WORDS; j++) begin : g_dc_do
        logic hit;
        assign hit = dc_wr_i && (dc_sel_i == SEL_W'(N_AO + j));
        assign dc_do_nx[j*WORD_W +: WORD_W] = hit ? dc_data_i : dc_do_q[j*WORD_W +: WORD_W];
        assign do_wr[j*WORD_W +: WORD_W]    = hit ? dc_data_i : do_q[j*WORD_W +: WORD_W];
    end

    // DC shadow: every valid DC write is stored whatever the mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dc_ao_q <= '0;
            dc_do_q <= '0;
        end else if (dc_valid) begin
            dc_ao_q <= dc_ao_nx;
            dc_do_q <= dc_do_nx;
        end
    end

    // Low-latency shadow, held for the next sample tick in clocked mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ll_ao_q   <= '0;
            ll_do_q   <= '0;
            ll_pend_q <= 1'b0;
        end else if (mode == MODE_LL_CLK && ll_wr_i) begin
            ll_ao_q   <= ll_ao_i;
            ll_do_q   <= ll_do_i;
            ll_pend_q <= 1'b1;
        end else if (mode == MODE_LL_CLK && sample_en_i) begin
            ll_pend_q <= 1'b0;
        end
    end

    // Output registers and the common update strobe, source chosen by mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ao_q  <= '0;
            do_q  <= '0;
            upd_q <= 1'b0;
        end else begin
            upd_q <= 1'b0;
            case (mode)
                MODE_REG_IMM: begin
                    if (dc_fire) begin
                        ao_q  <= dc_ao_q;
                        do_q  <= dc_do_q;
                        upd_q <= 1'b1;
                    end else if (dc_valid) begin
                        ao_q  <= ao_wr;
                        do_q  <= do_wr;
                        upd_q <= 1'b1;
                    end
                end
                MODE_REG_TRIG: begin
                    if (dc_fire) begin
                        ao_q  <= dc_ao_q;
                        do_q  <= dc_do_q;
                        upd_q <= 1'b1;
                    end
                end
                MODE_WAVE_IMM, MODE_WAVE_TRIG: begin
                    if (present) begin
                        ao_q  <= frame_ao;
                        do_q  <= frame_do;
                        upd_q <= 1'b1;
                    end
                end
                MODE_LL_IMM: begin
                    if (ll_wr_i) begin
                        ao_q  <= ll_ao_i;
                        do_q  <= ll_do_i;
                        upd_q <= 1'b1;
                    end
                end
                MODE_LL_CLK: begin
                    if (sample_en_i && ll_pend_q && !ll_wr_i) begin
                        ao_q  <= ll_ao_q;
                        do_q  <= ll_do_q;
                        upd_q <= 1'b1;
                    end
                end
                default: upd_q <= 1'b0;
            endcase
        end
    end

    assign ao_data_o = ao_q;
    assign do_data_o = do_q;
    assign upd_o     = upd_q;
endmodule

// File: rtl/wpb_seq_chk.sv
// Property checker for wpb_seq, attached by bind below.
// Assumes: observes top-level ports only.
module wpb_seq_chk #(
    parameter int AO_BUS = 512,
    parameter int DO_W   = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AO_BUS-1:0] ao_data_o,
    input logic [DO_W-1:0]   do_data_o,
    input logic              upd_o,
    input logic              playing_o,
    input logic              done_o,
    input logic              overrun_o,
    input logic              ovr_clr_i,
    input logic              commit_wr_i
);
    AST_OUT_ONLY_WITH_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ao_data_o) || !$stable(do_data_o)) |-> upd_o);   // R5

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && !ovr_clr_i) |=> overrun_o);   // R9

    AST_STARVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_o) |-> ($stable(ao_data_o) && $stable(do_data_o)));   // R9

    AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (!playing_o && upd_o));   // R7

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !commit_wr_i) |=> done_o);   // R7
endmodule

bind wpb_seq wpb_seq_chk #(.AO_BUS(N_AO * AO_W), .DO_W(DO_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ao_data_o   (ao_data_o),
    .do_data_o   (do_data_o),
    .upd_o       (upd_o),
    .playing_o   (playing_o),
    .done_o      (done_o),
    .overrun_o   (overrun_o),
    .ovr_clr_i   (ovr_clr_i),
    .commit_wr_i (commit_wr_i)
);

// File: tb/tb_wpb_seq.sv
`timescale 1ns/1ps
module tb_wpb_seq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   mode_i = '0;
    logic         commit_wr_i = 1'b0;
    logic [7:0]   commit_i = '0;
    logic         trig_i = 1'b0;
    logic         sample_en_i = 1'b0;
    logic         fifo_wr_i = 1'b0;
    logic [31:0]  fifo_wdata_i = '0;
    logic         fifo_full_o;
    logic [6:0]   fifo_level_o;
    logic [6:0]   lowtide_i = '0;
    logic [15:0]  frame_len_i = '0;
    logic         dc_wr_i = 1'b0;
    logic [5:0]   dc_sel_i = '0;
    logic [31:0]  dc_data_i = '0;
    logic         ll_wr_i = 1'b0;
    logic [511:0] ll_ao_i = '0;
    logic [63:0]  ll_do_i = '0;
    logic         ovr_clr_i = 1'b0;
    logic [511:0] ao_data_o;
    logic [63:0]  do_data_o;
    logic         upd_o, playing_o, done_o, overrun_o, lowtide_irq_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] m_ao [32];
    logic [63:0] m_do;
    logic [15:0] s_ao [32];
    logic [63:0] s_do;

    wpb_seq dut (.*);

    always #2.5 clk = ~clk;

    // DC write vectors: {select, data, expect strobe}
    localparam logic [38:0] DC_VEC [7] = '{
        {6'd0,  32'h0000_1234, 1'b1},
        {6'd31, 32'hFFFF_BEEF, 1'b1},
        {6'd5,  32'h0000_0A05, 1'b1},
        {6'd32, 32'hDEAD_BEEF, 1'b1},
        {6'd33, 32'hCAFE_F00D, 1'b1},
        {6'd40, 32'hFFFF_FFFF, 1'b0},
        {6'd63, 32'h1111_1111, 1'b0}
    };

    function automatic logic [15:0] ao_val(input int seed, input int c);
        return 16'((seed << 8) ^ (c * 37 + 1));
    endfunction

    function automatic logic [63:0] do_val(input int seed);
        return {32'(seed * 32'h0101_0101), 32'hA5A5_0000 | 32'(seed)};
    endfunction

    task automatic chk_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_outputs(input string req);
        bit ok = 1'b1;
        logic [63:0] a = '0, e = '0;
        for (int c = 0; c < 32; c++) begin
            if (ok && ao_data_o[c*16 +: 16] !== m_ao[c]) begin
                ok = 1'b0; a = 64'(ao_data_o[c*16 +: 16]); e = 64'(m_ao[c]);
            end
        end
        if (ok && do_data_o !== m_do) begin
            ok = 1'b0; a = do_data_o; e = m_do;
        end
        chk_eq(req, a, e);
    endtask

    task automatic model_seed(input int seed);
        for (int c = 0; c < 32; c++) m_ao[c] = ao_val(seed, c);
        m_do = do_val(seed);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic dc_write(input logic [5:0] sel, input logic [31:0] d);
        @(negedge clk);
        dc_wr_i = 1'b1; dc_sel_i = sel; dc_data_i = d;
        @(negedge clk);
        dc_wr_i = 1'b0;
        if (sel < 32) s_ao[sel] = d[15:0];
        else if (sel == 32) s_do[31:0] = d;
        else if (sel == 33) s_do[63:32] = d;
    endtask

    task automatic commit(input logic [7:0] w);
        @(negedge clk);
        commit_wr_i = 1'b1; commit_i = w;
        @(negedge clk);
        commit_wr_i = 1'b0;
    endtask

    task automatic trig();
        @(negedge clk); trig_i = 1'b1;
        @(negedge clk); trig_i = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); sample_en_i = 1'b1;
        @(negedge clk); sample_en_i = 1'b0;
    endtask

    task automatic ll_write(input int seed);
        @(negedge clk);
        for (int c = 0; c < 32; c++) ll_ao_i[c*16 +: 16] = ao_val(seed, c);
        ll_do_i = do_val(seed);
        ll_wr_i = 1'b1;
        @(negedge clk);
        ll_wr_i = 1'b0;
    endtask

    // Frame layout of R4: word k holds channels 2k (low) and 2k+1 (high)
    task automatic push_frame(input int seed);
        for (int w = 0; w < 18; w++) begin
            @(negedge clk);
            fifo_wr_i = 1'b1;
            if (w < 16) fifo_wdata_i = {ao_val(seed, 2*w+1), ao_val(seed, 2*w)};
            else if (w == 16) fifo_wdata_i = do_val(seed)[31:0];
            else fifo_wdata_i = do_val(seed)[63:32];
        end
        @(negedge clk);
        fifo_wr_i = 1'b0;
    endtask

    initial begin
        #(5ns * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 32; c++) begin m_ao[c] = '0; s_ao[c] = '0; end
        m_do = '0; s_do = '0;
        idle(4);
        chk_outputs("R1 outputs in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_outputs("R1 outputs after reset");
        chk_eq("R1 flags after reset", {59'd0, upd_o, playing_o, done_o, overrun_o, lowtide_irq_o}, 64'd0);

        // R2: table of DC writes in registered immediate mode
        mode_i = 3'd0;
        for (int v = 0; v < 7; v++) begin
            logic [5:0]  sel;
            logic [31:0] d;
            logic        exp_upd;
            {sel, d, exp_upd} = DC_VEC[v];
            dc_write(sel, d);
            if (sel < 32) m_ao[sel] = d[15:0];
            else if (sel == 32) m_do[31:0] = d;
            else if (sel == 33) m_do[63:32] = d;
            chk_eq("R2 strobe on DC write", 64'(upd_o), 64'(exp_upd));
            chk_outputs("R2 DC write result");
        end
        tick();
        chk_eq("R12 tick in registered mode strobe", 64'(upd_o), 64'd0);
        chk_outputs("R12 tick in registered mode");

        // R3: registered triggered update
        mode_i = 3'd1;
        dc_write(6'd3, 32'h0000_1111);
        chk_eq("R3 held DC write strobe", 64'(upd_o), 64'd0);
        chk_outputs("R3 held DC write");
        trig();
        chk_outputs("R3 unarmed trigger ignored");
        commit(8'h01);
        chk_outputs("R3 commit only arms");
        trig();
        m_ao[3] = 16'h1111;
        chk_eq("R3 triggered strobe", 64'(upd_o), 64'd1);
        chk_outputs("R3 triggered apply");
        dc_write(6'd4, 32'h0000_2222);
        trig();
        chk_outputs("R3 second trigger disarmed");

        // R5, R4, R8, R9: waveform immediate
        mode_i = 3'd2;
        lowtide_i = 7'd18;
        @(negedge clk);
        chk_eq("R8 irq idle with empty FIFO", 64'(lowtide_irq_o), 64'd0);
        push_frame(1);
        push_frame(2);
        commit(8'h02);
        chk_eq("R5 playing after commit", 64'(playing_o), 64'd1);
        idle(24);
        chk_eq("R8 irq at threshold", 64'(lowtide_irq_o), 64'd0);
        tick();
        model_seed(1);
        chk_eq("R5 frame strobe", 64'(upd_o), 64'd1);
        chk_outputs("R4 R5 first frame");
        idle(24);
        chk_eq("R8 irq below threshold", 64'(lowtide_irq_o), 64'd1);
        tick();
        model_seed(2);
        chk_outputs("R5 second frame");
        idle(4);
        tick();
        chk_eq("R9 starved strobe", 64'(upd_o), 64'd0);
        chk_eq("R9 overrun set", 64'(overrun_o), 64'd1);
        chk_outputs("R9 starved hold");
        dc_write(6'd7, 32'h0000_7777);
        chk_outputs("R12 DC write in wave mode");
        ll_write(33);
        chk_outputs("R12 LL write in wave mode");
        idle(3);
        chk_eq("R9 overrun sticky", 64'(overrun_o), 64'd1);
        @(negedge clk); ovr_clr_i = 1'b1;
        @(negedge clk); ovr_clr_i = 1'b0;
        chk_eq("R9 overrun cleared", 64'(overrun_o), 64'd0);
        commit(8'h00);
        chk_eq("R13 stop clears playing", 64'(playing_o), 64'd0);

        // R6, R7: waveform triggered one-shot of two frames
        mode_i = 3'd3;
        frame_len_i = 16'd2;
        push_frame(3);
        push_frame(4);
        push_frame(5);
        commit(8'h22);
        idle(24);
        tick();
        chk_eq("R6 armed not playing", 64'(playing_o), 64'd0);
        chk_outputs("R6 tick before trigger");
        trig();
        chk_eq("R6 trigger starts", 64'(playing_o), 64'd1);
        tick();
        model_seed(3);
        chk_outputs("R6 first triggered frame");
        chk_eq("R7 not done after one", 64'(done_o), 64'd0);
        idle(24);
        tick();
        model_seed(4);
        chk_outputs("R7 last one-shot frame");
        chk_eq("R7 done set", 64'(done_o), 64'd1);
        chk_eq("R7 stopped", 64'(playing_o), 64'd0);
        idle(24);
        tick();
        chk_eq("R7 hold strobe", 64'(upd_o), 64'd0);
        chk_outputs("R7 hold after done");
        chk_eq("R7 no overrun after done", 64'(overrun_o), 64'd0);

        // R7: continuous playback runs past the frame count
        mode_i = 3'd2;
        frame_len_i = 16'd1;
        commit(8'h02);
        chk_eq("R7 done cleared by commit", 64'(done_o), 64'd0);
        idle(24);
        tick();
        model_seed(5);
        chk_outputs("R7 continuous frame");
        chk_eq("R7 continuous still playing", 64'(playing_o), 64'd1);
        push_frame(6);
        idle(24);
        tick();
        model_seed(6);
        chk_outputs("R7 continuous past count");
        commit(8'h00);

        // R10: low-latency immediate
        mode_i = 3'd4;
        ll_write(9);
        model_seed(9);
        chk_eq("R10 strobe", 64'(upd_o), 64'd1);
        chk_outputs("R10 immediate vector");

        // R11: low-latency clocked
        mode_i = 3'd5;
        ll_write(10);
        chk_eq("R11 held strobe", 64'(upd_o), 64'd0);
        chk_outputs("R11 held until tick");
        tick();
        model_seed(10);
        chk_eq("R11 tick strobe", 64'(upd_o), 64'd1);
        chk_outputs("R11 applied on tick");

        // R2: commit bit 0 in registered immediate applies the whole shadow
        mode_i = 3'd0;
        commit(8'h01);
        for (int c = 0; c < 32; c++) m_ao[c] = s_ao[c];
        m_do = s_do;
        chk_eq("R2 commit apply strobe", 64'(upd_o), 64'd1);
        chk_outputs("R2 commit applies shadow");

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule